// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Controller

This block turns a single PWM command into two mutually exclusive gate-enable signals for the high-side and low-side switches of a synchronous buck stage. A PWM level of 1 asks for the high-side switch and a level of 0 asks for the low-side switch. Handover between the two switches is adaptive. The controller first drops the output that is on. It then waits for external comparator flags to show that this switch has really stopped conducting. Only after that does it count a programmable dead time and turn on the other output.

Three digital flags come from analog comparators outside the block. The first says the low-side gate is below its threshold. The second says the high-side gate-to-switch-node voltage is below its threshold. The third says the switch node is low. If the high-side gate is off but the switch node never falls, a fallback timeout lets the low-side handover go ahead. The low-side output also has a floor on its off time. Three inputs force both outputs off: an active-low output disable, a supply-lockout input and an over-temperature input. When the last of them is released, the sequencer restarts from an all-off state and follows the normal interlock.

Every input passes through a two-flop synchronizer. All delays are parameters counted in clock cycles: `DEAD_CYC`, `TIMEOUT_CYC` and `MIN_OFF_CYC`.

Top module: `gate_sequencer`

## Requirements
- R1: `hsOn` and `lsOn` are never 1 in the same cycle. When PWM is steady and the flags allow it, PWM=1 settles to `hsOn`=1 and PWM=0 settles to `lsOn`=1.
- R2: PWM rises while `lsOn`=1: `lsOn` is still 1 two cycles after the input change and is 0 three cycles after it. `hsOn` stays 0 for as long as `lsGateLow` is 0 (1 means the low-side gate is below threshold).
- R3: PWM is high and the low side is off. When `lsGateLow` goes from 0 to 1, `hsOn` goes to 1 exactly `DEAD_CYC`+3 cycles later.
- R4: PWM falls while `hsOn`=1: `hsOn` is 0 three cycles later. `lsOn` stays 0 for as long as `hsGateLow` is 0. If `swLow` is 1, `lsOn` goes to 1 exactly `DEAD_CYC`+3 cycles after `hsGateLow` goes to 1.
- R5: PWM is low, `hsGateLow` becomes 1 and `swLow` stays 0. In that case `lsOn` goes to 1 exactly `TIMEOUT_CYC`+`DEAD_CYC`+3 cycles later.
- R6: `outDisN`=0 forces both outputs to 0 three cycles after the input change. They stay 0 whatever PWM does.
- R7: `supplyLow`=1 or `overTemp`=1 forces both outputs to 0 three cycles after the input change. They stay 0 whatever PWM does.
- R8: Once `lsOn` falls, it stays 0 for at least `MIN_OFF_CYC` cycles. Take a one-cycle PWM high pulse with all three flags at 1: the high side never turns on, and `lsOn` is 0 for exactly `MIN_OFF_CYC` cycles.
- R9: If PWM reverses while a dead-time count is running, the pending turn-on is cancelled. The opposite handover sequence then runs.
- R10: When the forcing inputs are released, the sequencer starts from all-off. `hsOn` still waits for `lsGateLow`=1 and then for `DEAD_CYC`+3 cycles.
- R11: While `rstN`=0, both outputs are 0. The low-side off-time floor is also counted from reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pwmIn | input | 1 | PWM command: 1 requests the high side, 0 requests the low side |
| outDisN | input | 1 | Active-low output disable |
| supplyLow | input | 1 | Supply lockout, active high |
| overTemp | input | 1 | Over-temperature shutdown, active high |
| lsGateLow | input | 1 | 1 = low-side gate below threshold |
| hsGateLow | input | 1 | 1 = high-side gate-to-switch-node voltage below threshold |
| swLow | input | 1 | 1 = switch node low |
| hsOn | output | 1 | High-side gate enable |
| lsOn | output | 1 | Low-side gate enable |

## Verification
The bench holds one gate flag at "still on" and checks that the opposite output never appears. It then releases the flag and measures the exact cycle count to turn-on. This catches a design that times dead time from the PWM edge instead of from the feedback. A stuck-high switch node exercises the fallback timeout: a design without it would leave both switches off forever, and one that skips it would hand over early. The bench reverses PWM in the middle of a dead-time count in both directions. A design that does not cancel the count would turn on the wrong switch for at least one cycle. The bench also checks the low-side off-time floor, which a design could break by using the dead time alone, and it checks that restart after disable or a fault waits for the interlock instead of jumping straight to the requested switch.

// File: rtl/gate_seq_pkg.sv
`timescale 1ns/1ps
package gate_seq_pkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_LS_ON,
    ST_LS_WAIT,
    ST_HS_DEAD,
    ST_HS_ON,
    ST_HS_WAIT,
    ST_SW_WAIT,
    ST_LS_DEAD
  } seqState_t;

  // strobes from control to timers
  typedef struct packed {
    logic loadDead;
    logic loadTimeout;
    logic lsDrop;
  } timerCmd_t;

  // status from timers to control
  typedef struct packed {
    logic timerDone;
    logic minOffDone;
  } timerStat_t;

endpackage

// File: rtl/seq_sync.sv
`timescale 1ns/1ps
module seq_sync #(
  parameter int WIDTH = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] rawIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stage1;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stage1[i]  <= 1'b0;
        syncOut[i] <= 1'b0;
      end else begin
        stage1[i]  <= rawIn[i];
        syncOut[i] <= stage1[i];
      end
    end
  end

endmodule

// File: rtl/seq_timers.sv
`timescale 1ns/1ps
module seq_timers
  import gate_seq_pkg::*;
#(
  parameter int DEAD_CYC    = 4,
  parameter int TIMEOUT_CYC = 11,
  parameter int MIN_OFF_CYC = 20
) (
  input  logic       clk,
  input  logic       rstN,
  input  timerCmd_t  cmd,
  output timerStat_t stat
);

  localparam int SPAN = (DEAD_CYC > TIMEOUT_CYC) ? DEAD_CYC : TIMEOUT_CYC;
  localparam int CW   = $clog2(SPAN + 1);
  localparam int MW   = $clog2(MIN_OFF_CYC + 1);

  logic [CW-1:0] phaseCnt;
  logic [MW-1:0] offCnt;

  // shared dead-time / switch-node timeout counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                phaseCnt <= '0;
    else if (cmd.loadDead)    phaseCnt <= CW'(DEAD_CYC - 1);
    else if (cmd.loadTimeout) phaseCnt <= CW'(TIMEOUT_CYC - 1);
    else if (phaseCnt != '0)  phaseCnt <= phaseCnt - 1'b1;
  end

  // low-side off-time floor, armed from reset as well
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              offCnt <= MW'(MIN_OFF_CYC - 1);
    else if (cmd.lsDrop)    offCnt <= MW'(MIN_OFF_CYC - 1);
    else if (offCnt != '0)  offCnt <= offCnt - 1'b1;
  end

  assign stat.timerDone  = (phaseCnt == '0);
  assign stat.minOffDone = (offCnt == '0);

endmodule

// File: rtl/seq_ctrl.sv
`timescale 1ns/1ps
module seq_ctrl
  import gate_seq_pkg::*;
#(
  parameter int DEAD_CYC    = 4,
  parameter int MIN_OFF_CYC = 20
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pwm,
  input  logic       outDisN,
  input  logic       supplyLow,
  input  logic       overTemp,
  input  logic       lsGateLow,
  input  logic       hsGateLow,
  input  logic       swLow,
  input  timerStat_t stat,
  output timerCmd_t  cmd,
  output logic       hsOn,
  output logic       lsOn
);

  seqState_t state, nextState;
  logic forceOff;

  assign forceOff = !outDisN || supplyLow || overTemp;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_OFF;
    else       state <= nextState;
  end

  always_comb begin
    nextState       = state;
    cmd.loadDead    = 1'b0;
    cmd.loadTimeout = 1'b0;
    if (forceOff) begin
      nextState = ST_OFF;
    end else begin
      unique case (state)
        ST_OFF:     nextState = pwm ? ST_LS_WAIT : ST_HS_WAIT;
        ST_LS_ON:   if (pwm) nextState = ST_LS_WAIT;
        ST_LS_WAIT: begin
          if (!pwm) nextState = ST_HS_WAIT;
          else if (lsGateLow) begin
            nextState    = ST_HS_DEAD;
            cmd.loadDead = 1'b1;
          end
        end
        ST_HS_DEAD: begin
          if (!pwm)                nextState = ST_HS_WAIT;
          else if (stat.timerDone) nextState = ST_HS_ON;
        end
        ST_HS_ON:   if (!pwm) nextState = ST_HS_WAIT;
        ST_HS_WAIT: begin
          if (pwm) nextState = ST_LS_WAIT;
          else if (hsGateLow && swLow) begin
            nextState    = ST_LS_DEAD;
            cmd.loadDead = 1'b1;
          end else if (hsGateLow) begin
            nextState       = ST_SW_WAIT;
            cmd.loadTimeout = 1'b1;
          end
        end
        ST_SW_WAIT: begin
          if (pwm) nextState = ST_LS_WAIT;
          else if (swLow || stat.timerDone) begin
            nextState    = ST_LS_DEAD;
            cmd.loadDead = 1'b1;
          end
        end
        ST_LS_DEAD: begin
          if (pwm) nextState = ST_LS_WAIT;
          else if (stat.timerDone && stat.minOffDone) nextState = ST_LS_ON;
        end
        default:    nextState = ST_OFF;
      endcase
    end
  end

  assign cmd.lsDrop = (state == ST_LS_ON) && (nextState != ST_LS_ON);

  assign hsOn = (state == ST_HS_ON);
  assign lsOn = (state == ST_LS_ON);

  // ---- assertion support: saturating off-run counters ----
  localparam int RUN_CAP = ((MIN_OFF_CYC > DEAD_CYC) ? MIN_OFF_CYC : DEAD_CYC) + 1;
  localparam int RW      = $clog2(RUN_CAP + 1);
  logic [RW-1:0] lsLowRun, hsLowRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lsLowRun <= '0;
      hsLowRun <= '0;
    end else begin
      lsLowRun <= lsOn ? '0 : ((lsLowRun == RW'(RUN_CAP)) ? lsLowRun : lsLowRun + 1'b1);
      hsLowRun <= hsOn ? '0 : ((hsLowRun == RW'(RUN_CAP)) ? hsLowRun : hsLowRun + 1'b1);
    end
  end

  a_r1_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(hsOn && lsOn));

  a_r3_hs_dead_gap: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hsOn) |-> (lsLowRun >= RW'(DEAD_CYC)));

  a_r2_hs_from_dead: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hsOn) |-> $past(state == ST_HS_DEAD));

  a_r4_ls_dead_gap: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lsOn) |-> (hsLowRun >= RW'(DEAD_CYC)));

  a_r8_ls_min_off: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lsOn) |-> (lsLowRun >= RW'(MIN_OFF_CYC)));

  a_r6_disable_off: assert property (@(posedge clk) disable iff (!rstN)
    !outDisN |=> (!hsOn && !lsOn));

  a_r7_fault_off: assert property (@(posedge clk) disable iff (!rstN)
    (supplyLow || overTemp) |=> (!hsOn && !lsOn));

endmodule

// File: rtl/gate_sequencer.sv
`timescale 1ns/1ps
module gate_sequencer
  import gate_seq_pkg::*;
#(
  parameter int DEAD_CYC    = 4,
  parameter int TIMEOUT_CYC = 11,
  parameter int MIN_OFF_CYC = 20
) (
  input  logic clk,
  input  logic rstN,
  input  logic pwmIn,
  input  logic outDisN,
  input  logic supplyLow,
  input  logic overTemp,
  input  logic lsGateLow,
  input  logic hsGateLow,
  input  logic swLow,
  output logic hsOn,
  output logic lsOn
);

  localparam int NSYNC = 7;

  logic [NSYNC-1:0] rawVec, syncVec;
  timerCmd_t  cmd;
  timerStat_t stat;

  assign rawVec = {pwmIn, outDisN, supplyLow, overTemp, lsGateLow, hsGateLow, swLow};

  seq_sync #(.WIDTH(NSYNC)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .rawIn   (rawVec),
    .syncOut (syncVec)
  );

  seq_ctrl #(
    .DEAD_CYC    (DEAD_CYC),
    .MIN_OFF_CYC (MIN_OFF_CYC)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .pwm       (syncVec[6]),
    .outDisN   (syncVec[5]),
    .supplyLow (syncVec[4]),
    .overTemp  (syncVec[3]),
    .lsGateLow (syncVec[2]),
    .hsGateLow (syncVec[1]),
    .swLow     (syncVec[0]),
    .stat      (stat),
    .cmd       (cmd),
    .hsOn      (hsOn),
    .lsOn      (lsOn)
  );

  seq_timers #(
    .DEAD_CYC    (DEAD_CYC),
    .TIMEOUT_CYC (TIMEOUT_CYC),
    .MIN_OFF_CYC (MIN_OFF_CYC)
  ) u_timers (
    .clk  (clk),
    .rstN (rstN),
    .cmd  (cmd),
    .stat (stat)
  );

endmodule

// File: tb/sim_gate_sequencer.sv
`timescale 1ns/1ps
module sim_gate_sequencer;

  localparam int DEAD    = 4;
  localparam int TMO     = 11;
  localparam int MINOFF  = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pwmIn = 1'b0, outDisN = 1'b0, supplyLow = 1'b0, overTemp = 1'b0;
  logic lsGateLow = 1'b1, hsGateLow = 1'b1, swLow = 1'b1;
  logic hsOn, lsOn;

  int checks = 0;
  int errors = 0;
  int bothHigh = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gate_sequencer #(
    .DEAD_CYC(DEAD), .TIMEOUT_CYC(TMO), .MIN_OFF_CYC(MINOFF)
  ) u0 (
    .clk(clk), .rstN(rstN), .pwmIn(pwmIn), .outDisN(outDisN),
    .supplyLow(supplyLow), .overTemp(overTemp), .lsGateLow(lsGateLow),
    .hsGateLow(hsGateLow), .swLow(swLow), .hsOn(hsOn), .lsOn(lsOn)
  );

  always @(negedge clk) if (rstN && hsOn && lsOn) bothHigh++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitHigh(input bit wantHs, output int n);
    n = 0;
    while (n < 200) begin
      @(negedge clk);
      n++;
      if (wantHs ? hsOn : lsOn) break;
    end
  endtask

  task automatic t_reset;
    step(3);
    check(!hsOn && !lsOn, "R11 outputs low in reset", {hsOn, lsOn}, 0);
    rstN = 1'b1;
    step(2);
    outDisN = 1'b1;
    step(40);
    check(lsOn && !hsOn, "R1 pwm low selects low side", {hsOn, lsOn}, 1);
  endtask

  task automatic t_rise_interlock;
    int n;
    lsGateLow = 1'b0;
    pwmIn = 1'b1;
    step(2);
    check(lsOn, "R2 low side still on at cycle 2", lsOn, 1);
    step(1);
    check(!lsOn, "R2 low side off at cycle 3", lsOn, 0);
    step(12);
    check(!hsOn, "R2 high side held while low gate high", hsOn, 0);
    lsGateLow = 1'b1;
    waitHigh(1'b1, n);
    check(n == DEAD + 3, "R3 high side delay after low gate flag", n, DEAD + 3);
    step(20);
  endtask

  task automatic t_fall_swnode;
    int n;
    hsGateLow = 1'b0;
    swLow = 1'b1;
    pwmIn = 1'b0;
    step(3);
    check(!hsOn, "R4 high side off at cycle 3", hsOn, 0);
    step(12);
    check(!lsOn, "R4 low side held while high gate high", lsOn, 0);
    hsGateLow = 1'b1;
    waitHigh(1'b0, n);
    check(n == DEAD + 3, "R4 low side delay after high gate flag", n, DEAD + 3);
    step(20);
  endtask

  task automatic t_timeout;
    int n;
    pwmIn = 1'b1;
    step(30);
    check(hsOn && !lsOn, "R1 pwm high selects high side", {hsOn, lsOn}, 2);
    hsGateLow = 1'b0;
    swLow = 1'b0;
    pwmIn = 1'b0;
    step(15);
    check(!lsOn, "R5 low side held before gate flag", lsOn, 0);
    hsGateLow = 1'b1;
    waitHigh(1'b0, n);
    check(n == TMO + DEAD + 3, "R5 switch-node fallback timeout", n, TMO + DEAD + 3);
    swLow = 1'b1;
    step(30);
  endtask

  task automatic t_min_off;
    int n;
    bit hsSeen = 1'b0;
    pwmIn = 1'b1;
    step(1);
    pwmIn = 1'b0;
    step(2);
    check(!lsOn, "R8 low side dropped by pulse", lsOn, 0);
    n = 1;
    while (n < 200) begin
      @(negedge clk);
      if (hsOn) hsSeen = 1'b1;
      if (lsOn) break;
      n++;
    end
    check(n == MINOFF, "R8 low side minimum off time", n, MINOFF);
    check(!hsSeen, "R8 high side not driven by short pulse", hsSeen, 0);
    step(10);
  endtask

  task automatic t_cancel_hs;
    bit hsSeen = 1'b0;
    pwmIn = 1'b1;
    step(3);
    pwmIn = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (hsOn) hsSeen = 1'b1;
    end
    check(!hsSeen, "R9 pending high side turn-on cancelled", hsSeen, 0);
    check(lsOn, "R9 low side restored after cancel", lsOn, 1);
  endtask

  task automatic t_cancel_ls;
    bit lsSeen = 1'b0;
    pwmIn = 1'b1;
    step(40);
    check(hsOn, "R9 high side reached before reversal", hsOn, 1);
    pwmIn = 1'b0;
    step(3);
    pwmIn = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (lsOn) lsSeen = 1'b1;
    end
    check(!lsSeen, "R9 pending low side turn-on cancelled", lsSeen, 0);
    check(hsOn, "R9 high side restored after cancel", hsOn, 1);
  endtask

  task automatic t_disable;
    int n;
    outDisN = 1'b0;
    step(2);
    check(hsOn, "R6 high side on before disable reaches", hsOn, 1);
    step(1);
    check(!hsOn, "R6 disable forces high side off", hsOn, 0);
    pwmIn = 1'b0;
    step(30);
    check(!hsOn && !lsOn, "R6 outputs off with pwm low", {hsOn, lsOn}, 0);
    pwmIn = 1'b1;
    lsGateLow = 1'b0;
    step(5);
    outDisN = 1'b1;
    step(20);
    check(!hsOn && !lsOn, "R10 restart waits for low gate flag", {hsOn, lsOn}, 0);
    lsGateLow = 1'b1;
    waitHigh(1'b1, n);
    check(n == DEAD + 3, "R10 restart high side delay", n, DEAD + 3);
  endtask

  task automatic t_faults;
    pwmIn = 1'b0;
    step(40);
    check(lsOn, "R7 low side on before lockout", lsOn, 1);
    supplyLow = 1'b1;
    step(3);
    check(!lsOn, "R7 lockout forces low side off", lsOn, 0);
    pwmIn = 1'b1;
    step(20);
    check(!hsOn && !lsOn, "R7 lockout holds both off", {hsOn, lsOn}, 0);
    supplyLow = 1'b0;
    pwmIn = 1'b0;
    step(40);
    check(lsOn, "R10 low side back after lockout", lsOn, 1);
    overTemp = 1'b1;
    step(3);
    check(!lsOn, "R7 over-temperature forces low side off", lsOn, 0);
    step(20);
    check(!hsOn && !lsOn, "R7 over-temperature holds both off", {hsOn, lsOn}, 0);
    overTemp = 1'b0;
    step(40);
    check(lsOn, "R10 low side back after over-temperature", lsOn, 1);
  endtask

  initial begin
    t_reset();
    t_rise_interlock();
    t_fall_swnode();
    t_timeout();
    t_min_off();
    t_cancel_hs();
    t_cancel_ls();
    t_disable();
    t_faults();
    check(bothHigh == 0, "R1 outputs never both high", bothHigh, 0);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule